// File: doc/BRIEF.md
# RTC Status and Interrupt Controller

This block holds the status, interrupt-enable and wake-enable registers of a real-time clock. The clock core sends it event pulses together with a 32 kHz tick enable. The block turns those pulses into readable flags, a timer interrupt, an alarm interrupt and a wake output. Software reaches the three registers through a byte-wide port. Writes take effect on a clock edge. Reads are combinational on the current address.

The power-up flag is set by reset and holds until software writes a one to it. The alarm flag works the same way: it stays set until a write-one clears it. The four periodic flags (second, minute, hour, day) show the events of the most recent tick. BUSY warns software, for one tick period, that the time registers are about to roll over. RUN reports the run request once a tick has sampled it.

Top module: `rtcst_top`

## Requirements
- R1: After reset the status register (address 0x44) reads 0x80, the interrupt-enable (0x48) and wake-enable (0x7C) registers read 0x00, and irqTimer, irqAlarm and wakeOut are low.
- R2: A status write with bit 7 set clears the power-up flag. A status write with bit 6 set clears the alarm flag, except when an alarm event arrives in the same cycle; the event wins.
- R3: Status bits written as 0, and status bits 5 to 0 whatever their value, leave the status register unchanged.
- R4: At a tick with evtAlarm high, the alarm flag (status bit 6) is set. It stays set until cleared as in R2.
- R5: At each tick, status bits 5, 4, 3 and 2 load evtDay, evtHour, evtMin and evtSec. Between ticks they hold, and event inputs without tickEn are ignored.
- R6: At each tick, status bit 0 (busy) loads updateSoon. It holds between ticks.
- R7: At each tick, status bit 1 (running) loads runReq. It holds between ticks.
- R8: In the interrupt-enable register, bit 3 is the alarm enable and bit 2 the timer enable. Its other bits read 0. irqAlarm is high whenever both the alarm flag and bit 3 are set.
- R9: irqTimer is high for exactly the cycle after an edge that sees tickEn and evtSec with the timer enable set. It is low otherwise.
- R10: In the wake-enable register, bit 1 is the alarm wake enable. Its other bits read 0. wakeOut is high whenever both the alarm flag and that bit are set.
- R11: Any other address reads 0x00, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| tickEn | input | 1 | One-cycle 32 kHz tick enable |
| updateSoon | input | 1 | Clock core will roll the time at the next tick |
| runReq | input | 1 | Control run bit from the clock core |
| evtSec | input | 1 | Second event (valid with tickEn) |
| evtMin | input | 1 | Minute event (valid with tickEn) |
| evtHour | input | 1 | Hour event (valid with tickEn) |
| evtDay | input | 1 | Day event (valid with tickEn) |
| evtAlarm | input | 1 | Alarm match event (valid with tickEn) |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr |
| irqTimer | output | 1 | Periodic timer interrupt pulse |
| irqAlarm | output | 1 | Alarm interrupt level |
| wakeOut | output | 1 | Alarm wake request |

## Verification
Directed sequences come first. They cover write-one and write-zero patterns on the sticky flags, which tell a true write-one-to-clear apart from a plain load. A clear that collides with an alarm event shows which of the two takes priority. Ticks with and without events separate the reload of the periodic flags from their hold. A long pseudo-random phase then mixes sparse ticks, event inputs that toggle off tick, and writes to mapped and unmapped addresses. A cycle-accurate model checks every output on every clock, which exposes leaks through the tick gating and stray writes.

// File: rtl/rtcst_pkg.sv
package rtcst_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h44;
  localparam logic [ADDR_W-1:0] ADDR_IRQEN  = 8'h48;
  localparam logic [ADDR_W-1:0] ADDR_WAKE   = 8'h7C;

  localparam int BIT_PWR   = 7;
  localparam int BIT_ALM   = 6;
  localparam int BIT_PER0  = 2;   // second, minute, hour, day at 2..5
  localparam int NUM_PER   = 4;
  localparam int BIT_RUN   = 1;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_AEN   = 3;
  localparam int BIT_TEN   = 2;
  localparam int BIT_WAKE  = 1;

  localparam logic [DATA_W-1:0] STICKY_MASK = (DATA_W'(1) << BIT_PWR) | (DATA_W'(1) << BIT_ALM);
  localparam logic [DATA_W-1:0] IRQ_MASK    = (DATA_W'(1) << BIT_AEN) | (DATA_W'(1) << BIT_TEN);
  localparam logic [DATA_W-1:0] WAKE_MASK   = DATA_W'(1) << BIT_WAKE;

  typedef struct packed {
    logic tick;
    logic wrStatus;
    logic wrIrqEn;
    logic wrWake;
    logic selStatus;
    logic selIrqEn;
    logic selWake;
  } ctlStrobes_t;
endpackage

// File: rtl/rtcst_ctrl.sv
module rtcst_ctrl
  import rtcst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              updateSoon,
  input  logic              runReq,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output ctlStrobes_t       strobes,
  output logic              busy,
  output logic              running
);
  logic hitStatus, hitIrq, hitWake;

  always_comb begin
    hitStatus = (addr == ADDR_STATUS);
    hitIrq    = (addr == ADDR_IRQEN);
    hitWake   = (addr == ADDR_WAKE);
    strobes.tick      = tickEn;
    strobes.wrStatus  = wrEn & hitStatus;
    strobes.wrIrqEn   = wrEn & hitIrq;
    strobes.wrWake    = wrEn & hitWake;
    strobes.selStatus = hitStatus;
    strobes.selIrqEn  = hitIrq;
    strobes.selWake   = hitWake;
  end

  // busy and running are resampled only on the slow tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      running <= 1'b0;
    end else if (tickEn) begin
      busy    <= updateSoon;
      running <= runReq;
    end
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(busy)); // R6
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(running)); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.wrStatus, strobes.wrIrqEn, strobes.wrWake})); // R11
endmodule

// File: rtl/rtcst_dp.sv
module rtcst_dp
  import rtcst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              evtSec,
  input  logic              evtMin,
  input  logic              evtHour,
  input  logic              evtDay,
  input  logic              evtAlarm,
  input  logic              busy,
  input  logic              running,
  output logic [DATA_W-1:0] rdData,
  output logic              irqTimer,
  output logic              irqAlarm,
  output logic              wakeOut
);
  localparam logic [DATA_W-1:0] STICKY_RST = DATA_W'(1) << BIT_PWR;

  logic [DATA_W-1:0]  sticky, stickySet, stickyClr;
  logic [DATA_W-1:0]  irqEn, wakeEn, statusWord;
  logic [NUM_PER-1:0] evtVec, perFlags;

  assign evtVec = {evtDay, evtHour, evtMin, evtSec};

  // sticky flags: write-one-to-clear, a same-cycle set wins
  always_comb begin
    stickySet = '0;
    stickySet[BIT_ALM] = strobes.tick & evtAlarm;
    stickyClr = strobes.wrStatus ? wrData : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sticky <= STICKY_RST;
    else       sticky <= ((sticky & ~stickyClr) | stickySet) & STICKY_MASK;
  end

  // periodic event flags reload at every tick
  for (genvar g = 0; g < NUM_PER; g++) begin : genPer
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             perFlags[g] <= 1'b0;
      else if (strobes.tick) perFlags[g] <= evtVec[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqEn    <= '0;
      wakeEn   <= '0;
      irqTimer <= 1'b0;
    end else begin
      irqTimer <= strobes.tick & evtSec & irqEn[BIT_TEN];
      if (strobes.wrIrqEn) irqEn  <= wrData & IRQ_MASK;
      if (strobes.wrWake)  wakeEn <= wrData & WAKE_MASK;
    end
  end

  always_comb begin
    statusWord = sticky;
    statusWord[BIT_PER0 +: NUM_PER] = perFlags;
    statusWord[BIT_RUN]  = running;
    statusWord[BIT_BUSY] = busy;
    rdData = '0;
    if (strobes.selStatus)     rdData = statusWord;
    else if (strobes.selIrqEn) rdData = irqEn;
    else if (strobes.selWake)  rdData = wakeEn;
  end

  assign irqAlarm = sticky[BIT_ALM] & irqEn[BIT_AEN];
  assign wakeOut  = sticky[BIT_ALM] & wakeEn[BIT_WAKE];

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (sticky[BIT_ALM] && !(strobes.wrStatus && wrData[BIT_ALM])) |=> sticky[BIT_ALM]); // R4
  AST_ALARM_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && evtAlarm) |=> sticky[BIT_ALM]); // R2
  AST_PWR_NO_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !sticky[BIT_PWR] |=> !sticky[BIT_PWR]); // R2
  AST_TIMER_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> !irqTimer); // R9
  AST_PER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(perFlags)); // R5
endmodule

// File: rtl/rtcst_top.sv
module rtcst_top
  import rtcst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              updateSoon,
  input  logic              runReq,
  input  logic              evtSec,
  input  logic              evtMin,
  input  logic              evtHour,
  input  logic              evtDay,
  input  logic              evtAlarm,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqTimer,
  output logic              irqAlarm,
  output logic              wakeOut
);
  ctlStrobes_t strobes;
  logic        busy, running;

  rtcst_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .updateSoon(updateSoon),
    .runReq(runReq), .wrEn(wrEn), .addr(addr),
    .strobes(strobes), .busy(busy), .running(running)
  );

  rtcst_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .evtSec(evtSec), .evtMin(evtMin), .evtHour(evtHour), .evtDay(evtDay),
    .evtAlarm(evtAlarm), .busy(busy), .running(running),
    .rdData(rdData), .irqTimer(irqTimer), .irqAlarm(irqAlarm), .wakeOut(wakeOut)
  );

  AST_ALARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (irqAlarm || wakeOut) |-> $past(irqAlarm || wakeOut || tickEn || wrEn)); // R8
endmodule

// File: tb/tb_rtcst_top.sv
module tb_rtcst_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 0, updateSoon = 0, runReq = 0;
  logic evtSec = 0, evtMin = 0, evtHour = 0, evtDay = 0, evtAlarm = 0;
  logic wrEn = 0;
  logic [7:0] addr = 8'h44, wrData = 8'h00;
  logic [7:0] rdData;
  logic irqTimer, irqAlarm, wakeOut;

  int nChecks = 0, nFails = 0;
  bit cmpOn = 0, finished = 0;

  // behavioural reference state
  bit mPwr, mAlm, mDay, mHr, mMin, mSec, mRun, mBusy, mAen, mTen, mWen, mIrqT;

  always #4 clk = ~clk;

  rtcst_top dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .updateSoon(updateSoon),
    .runReq(runReq), .evtSec(evtSec), .evtMin(evtMin), .evtHour(evtHour),
    .evtDay(evtDay), .evtAlarm(evtAlarm), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqTimer(irqTimer),
    .irqAlarm(irqAlarm), .wakeOut(wakeOut)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPwr = 1; mAlm = 0; mDay = 0; mHr = 0; mMin = 0; mSec = 0;
      mRun = 0; mBusy = 0; mAen = 0; mTen = 0; mWen = 0; mIrqT = 0;
    end else begin
      mIrqT = tickEn && evtSec && mTen;
      if (wrEn && addr == 8'h44) begin
        if (wrData[7]) mPwr = 0;
        if (wrData[6]) mAlm = 0;
      end
      if (wrEn && addr == 8'h48) begin mAen = wrData[3]; mTen = wrData[2]; end
      if (wrEn && addr == 8'h7C) mWen = wrData[1];
      if (tickEn) begin
        mDay = evtDay; mHr = evtHour; mMin = evtMin; mSec = evtSec;
        mBusy = updateSoon; mRun = runReq;
        if (evtAlarm) mAlm = 1;
      end
    end
  end

  function automatic logic [7:0] modelRead(input logic [7:0] a);
    case (a)
      8'h44: return {mPwr, mAlm, mDay, mHr, mMin, mSec, mRun, mBusy};
      8'h48: return {4'b0, mAen, mTen, 2'b0};
      8'h7C: return {6'b0, mWen, 1'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (cmpOn && rstN) begin
      check("R11 rdData vs model", rdData, modelRead(addr));
      check("R9 irqTimer vs model", {7'b0, irqTimer}, {7'b0, mIrqT});
      check("R8 irqAlarm vs model", {7'b0, irqAlarm}, {7'b0, mAlm & mAen});
      check("R10 wakeOut vs model", {7'b0, wakeOut}, {7'b0, mAlm & mWen});
    end
  end

  task automatic cyc; @(posedge clk); #2; endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wrData = d; wrEn = 1; cyc; wrEn = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1; check(tag, rdData, exp);
  endtask

  task automatic tickWith(input logic s, input logic m, input logic h, input logic d,
                          input logic al, input logic us, input logic rr);
    tickEn = 1; evtSec = s; evtMin = m; evtHour = h; evtDay = d;
    evtAlarm = al; updateSoon = us; runReq = rr;
    cyc;
    tickEn = 0; evtSec = 0; evtMin = 0; evtHour = 0; evtDay = 0; evtAlarm = 0;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #13 rstN = 1;
    cyc;
    cmpOn = 1;
    // R1 reset state
    rd(8'h44, 8'h80, "R1 status after reset");
    rd(8'h48, 8'h00, "R1 irq enable after reset");
    rd(8'h7C, 8'h00, "R1 wake enable after reset");
    check("R1 outputs low", {5'b0, irqTimer, irqAlarm, wakeOut}, 8'h00);
    // R3 zero and low-bit writes
    wr(8'h44, 8'h00); rd(8'h44, 8'h80, "R3 write zero");
    wr(8'h44, 8'h3F); rd(8'h44, 8'h80, "R3 low bits ignored");
    // R2 clear power-up
    wr(8'h44, 8'h80); rd(8'h44, 8'h00, "R2 power-up cleared");
    // R4 alarm set and sticky
    tickWith(0, 0, 0, 0, 1, 0, 0);
    rd(8'h44, 8'h40, "R4 alarm set");
    cyc; cyc; cyc;
    rd(8'h44, 8'h40, "R4 alarm sticky");
    // R8 enables
    wr(8'h48, 8'h08); rd(8'h48, 8'h08, "R8 alarm enable");
    check("R8 irqAlarm high", {7'b0, irqAlarm}, 8'h01);
    wr(8'h48, 8'hFF); rd(8'h48, 8'h0C, "R8 unused bits read zero");
    // R10 wake
    wr(8'h7C, 8'hFF); rd(8'h7C, 8'h02, "R10 wake bits");
    check("R10 wakeOut high", {7'b0, wakeOut}, 8'h01);
    // R2 set wins over clear
    addr = 8'h44; wrData = 8'h40; wrEn = 1; tickEn = 1; evtAlarm = 1; cyc;
    wrEn = 0; tickEn = 0; evtAlarm = 0;
    rd(8'h44, 8'h40, "R2 set wins");
    wr(8'h44, 8'h40); rd(8'h44, 8'h00, "R2 alarm cleared");
    check("R2 irqAlarm/wake drop", {6'b0, irqAlarm, wakeOut}, 8'h00);
    // R5 R6 R7 R9 tick behaviour
    addr = 8'h44;
    tickWith(1, 0, 0, 1, 0, 1, 1);
    check("R9 irqTimer pulse", {7'b0, irqTimer}, 8'h01);
    rd(8'h44, 8'h27, "R5 R6 R7 tick load");
    evtSec = 1; evtMin = 1; evtAlarm = 1; cyc;
    evtSec = 0; evtMin = 0; evtAlarm = 0;
    check("R9 irqTimer single cycle", {7'b0, irqTimer}, 8'h00);
    rd(8'h44, 8'h27, "R5 events without tick ignored");
    tickWith(0, 0, 0, 0, 0, 0, 0);
    rd(8'h44, 8'h00, "R5 R6 R7 reload clear");
    // R11 unmapped address
    wr(8'h40, 8'hFF);
    rd(8'h40, 8'h00, "R11 unmapped reads zero");
    rd(8'h44, 8'h00, "R11 status untouched");
    rd(8'h48, 8'h0C, "R11 irq untouched");
    rd(8'h7C, 8'h02, "R11 wake untouched");
    // random mixed phase
    for (int i = 0; i < 4000; i++) begin
      int pick;
      tickEn = ($urandom % 4) == 0;
      evtSec = $urandom; evtMin = $urandom; evtHour = $urandom;
      evtDay = $urandom; evtAlarm = ($urandom % 5) == 0;
      updateSoon = $urandom; runReq = $urandom;
      wrEn = ($urandom % 6) == 0;
      wrData = 8'($urandom);
      pick = $urandom % 5;
      addr = (pick == 0) ? 8'h44 : (pick == 1) ? 8'h48 : (pick == 2) ? 8'h7C :
             (pick == 3) ? 8'h40 : 8'h00;
      cyc;
    end
    wrEn = 0; tickEn = 0;
    cyc; cyc;
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule